// File: doc/BRIEF.md
# SDLC Loop Repeater Controller

This block decides how a serial station sits on an SDLC loop. It steers the station's transmit pin between three sources. The first is the live receive pin, passed through gating alone. The second is the receive stream repeated through a one-bit register. The third is the station's own transmit shifter. It watches the received bits for an end-of-poll pattern, which is a 0 followed by seven 1s. It keeps the go-active-on-poll permission bit. It samples that bit at every flag boundary that the local shifter reports. From these it decides when to insert the repeat delay, when to seize the loop, and when to hand the loop back.

Data moves one bit per `bit_tick` strobe. The serial path has no valid/ready handshake and no back-pressure, because a loop line cannot stall. Every bit present on `rxd` at a tick is accepted. The bit on `txd` is meaningful for the whole bit period that follows. Framing, CRC and zero insertion of the local frame belong to the transmit shifter. This block only tells that shifter when it may shift (`tx_go`) and whether its next unit is a data byte or a flag (`tx_next_data`).

Top module: `sdlc_loop_repeater`

## Requirements
- R1: While loop operation is active (`loop_en`=1 and `sync_mode`=1) and the state is BYPASS, `txd` equals `rxd` in the same clock cycle, with no register in the path.
- R2: In BYPASS, a tick that completes the end-of-poll pattern moves the state to ON_LOOP_REPEAT, but only if the poll bit is set. The pattern is the last eight received bits, oldest first, reading 0,1,1,1,1,1,1,1, with the bit on `rxd` at that tick as the newest. Without the poll bit the state stays BYPASS. In ON_LOOP_REPEAT, `txd` is the `rxd` value captured at the previous tick.
- R3: In ON_LOOP_REPEAT, an end-of-poll tick moves the state to ACTIVE_TX only if the poll bit is set and the block is armed. Entry from BYPASS arms it. For the bit period after that tick, `txd` is 0, so the repeated bits form 01111110. From the next tick on, `tx_go`=1 and `txd` follows `tx_bit`.
- R4: A `flag_done` strobe while `tx_go`=1 and the poll bit is set keeps ACTIVE_TX. It loads `tx_next_data` with `tx_buf_full`: 1 means a data byte follows, 0 means another flag.
- R5: A `flag_done` strobe while `tx_go`=1 and the poll bit is clear returns the state to ON_LOOP_REPEAT on the next clock. `txd` is then the one-bit-delayed receive stream again, and `tx_next_data` is 0. Without `flag_done` the state never leaves ACTIVE_TX while loop operation stays active.
- R6: After such a release the block is disarmed. An end-of-poll pattern does not cause ACTIVE_TX until a received flag (0,1,1,1,1,1,1,0, oldest first) has re-armed it, followed by an end-of-poll pattern. The flag's closing 0 may be the pattern's leading 0.
- R7: With `loop_en`=0 or `sync_mode`=0, the state is forced to BYPASS on the next clock. In that condition `txd` equals `tx_bit` and the poll bit has no effect.
- R8: The poll bit (`poll_q`) is loaded by `poll_wr` with `poll_wdata`. It is cleared by `rst_n`=0 and by `chan_rst`=1, and `chan_rst` wins over a write in the same cycle. `chan_rst` also returns the state to BYPASS, disarms the block and clears the received-bit history to zeros.
- R9: `eop_pulse` is high for exactly the one clock that follows each tick completing an end-of-poll pattern, in every state and mode.
- R10: `loop_state` encodes BYPASS=0, ON_LOOP_REPEAT=1 and ACTIVE_TX=2. After reset it reads BYPASS, and `poll_q`, `tx_go`, `tx_next_data` and `eop_pulse` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| chan_rst | input | 1 | Channel reset, synchronous, active high |
| sync_mode | input | 1 | 1 = synchronous operation, 0 = asynchronous |
| loop_en | input | 1 | Loop operation enable |
| poll_wr | input | 1 | Write strobe for the poll bit |
| poll_wdata | input | 1 | Value written to the poll bit |
| bit_tick | input | 1 | One-cycle strobe per bit period |
| rxd | input | 1 | Serial receive data |
| tx_bit | input | 1 | Serial bit from the local transmit shifter |
| flag_done | input | 1 | Strobe: a flag has just left the transmit shifter |
| tx_buf_full | input | 1 | Transmit buffer holds a byte |
| txd | output | 1 | Serial transmit data |
| loop_state | output | 2 | Loop state (0 BYPASS, 1 ON_LOOP_REPEAT, 2 ACTIVE_TX) |
| tx_go | output | 1 | Local shifter may drive `txd` |
| tx_next_data | output | 1 | Next unit after a flag: 1 data byte, 0 flag |
| eop_pulse | output | 1 | One-clock pulse per detected end-of-poll |
| poll_q | output | 1 | Current value of the go-active-on-poll bit |

## Verification
The assertions assume the following about the inputs. `bit_tick` is a single-cycle strobe. `flag_done` arrives as a single-cycle strobe only while `tx_go` is high. All inputs change synchronously to `clk`. The bench drives every input just after the falling edge. It spaces ticks three clocks apart and raises `flag_done` only in ACTIVE_TX, after the hold bit has gone out. It feeds received patterns as whole bit periods, so a pattern is never split by a mode change.

// File: rtl/loop_rep_pkg.sv
package loop_rep_pkg;

  typedef enum logic [1:0] {
    ST_BYPASS  = 2'd0,
    ST_ON_LOOP = 2'd1,
    ST_ACTIVE  = 2'd2
  } loop_state_e;

  localparam int unsigned PAT_W = 8;

endpackage

// File: rtl/loop_poll_bit.sv
module loop_poll_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic chan_rst,
  input  logic wr,
  input  logic wdata,
  output logic q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= 1'b0;
    else if (chan_rst) q <= 1'b0;
    else if (wr)       q <= wdata;
  end

  // R8: a channel reset leaves the bit clear, even against a write
  assert_chan_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    chan_rst |=> !q);

  // R8: the bit only moves on a write strobe
  assert_hold_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && !chan_rst) |=> $stable(q));

endmodule

// File: rtl/loop_pat_det.sv
module loop_pat_det #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] EOP_PAT  = 8'b0111_1111,
  parameter logic [W-1:0] FLAG_PAT = 8'b0111_1110
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  input  logic rxd,
  output logic eop_hit,
  output logic flag_hit,
  output logic eop_pulse
);

  logic [W-1:0] win;
  logic [W-1:0] win_nxt;

  assign win_nxt  = {win[W-2:0], rxd};
  assign eop_hit  = (win_nxt == EOP_PAT);
  assign flag_hit = (win_nxt == FLAG_PAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win       <= '0;
      eop_pulse <= 1'b0;
    end else if (clr) begin
      win       <= '0;
      eop_pulse <= 1'b0;
    end else begin
      eop_pulse <= tick & eop_hit;
      if (tick) win <= win_nxt;
    end
  end

  // R9: a pulse always follows a tick
  assert_pulse_after_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    eop_pulse |-> $past(tick));

  // R9: pulses last one clock when ticks are single-cycle
  assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (eop_pulse && !tick) |=> !eop_pulse);

endmodule

// File: rtl/loop_seq.sv
module loop_seq
  import loop_rep_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        chan_rst,
  input  logic        loop_act,
  input  logic        tick,
  input  logic        eop_hit,
  input  logic        flag_hit,
  input  logic        poll_eff,
  input  logic        flag_done,
  input  logic        buf_full,
  output loop_state_e st,
  output logic        hold,
  output logic        go_active,
  output logic        next_data
);

  loop_state_e st_n;
  logic        armed, armed_n, hold_n, nd_n;

  always_comb begin
    st_n      = st;
    armed_n   = armed;
    hold_n    = hold;
    nd_n      = next_data;
    go_active = 1'b0;
    if (!loop_act) begin
      st_n    = ST_BYPASS;
      armed_n = 1'b0;
      hold_n  = 1'b0;
      nd_n    = 1'b0;
    end else begin
      unique case (st)
        ST_BYPASS: begin
          if (tick && eop_hit && poll_eff) begin
            st_n    = ST_ON_LOOP;
            armed_n = 1'b1;
          end
        end
        ST_ON_LOOP: begin
          if (tick && flag_hit) armed_n = 1'b1;
          if (tick && eop_hit && poll_eff && armed) begin
            st_n      = ST_ACTIVE;
            hold_n    = 1'b1;
            go_active = 1'b1;
          end
        end
        ST_ACTIVE: begin
          if (hold) begin
            if (tick) hold_n = 1'b0;
          end else if (flag_done) begin
            if (poll_eff) begin
              nd_n = buf_full;
            end else begin
              st_n    = ST_ON_LOOP;
              armed_n = 1'b0;
              nd_n    = 1'b0;
            end
          end
        end
        default: st_n = ST_BYPASS;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_BYPASS;
      armed     <= 1'b0;
      hold      <= 1'b0;
      next_data <= 1'b0;
    end else if (chan_rst) begin
      st        <= ST_BYPASS;
      armed     <= 1'b0;
      hold      <= 1'b0;
      next_data <= 1'b0;
    end else begin
      st        <= st_n;
      armed     <= armed_n;
      hold      <= hold_n;
      next_data <= nd_n;
    end
  end

  // R2: the transmitter is never seized straight from the bypass path
  assert_no_skip_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BYPASS) |=> (st != ST_ACTIVE));

  // R3: the inserted zero lasts exactly one bit period
  assert_hold_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && tick && loop_act && !chan_rst) |=> !hold);

  // R5: the loop is handed back only at a flag boundary
  assert_release_at_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ACTIVE && loop_act && !chan_rst && !flag_done) |=> (st == ST_ACTIVE));

  // R6: a disarmed station cannot seize the loop
  assert_armed_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ON_LOOP && !armed) |=> (st != ST_ACTIVE));

  // R7: loop operation off forces the bypass state
  assert_loop_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_act |=> (st == ST_BYPASS));

endmodule

// File: rtl/sdlc_loop_repeater.sv
module sdlc_loop_repeater
  import loop_rep_pkg::*;
#(
  parameter int unsigned W = PAT_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       chan_rst,
  input  logic       sync_mode,
  input  logic       loop_en,
  input  logic       poll_wr,
  input  logic       poll_wdata,
  input  logic       bit_tick,
  input  logic       rxd,
  input  logic       tx_bit,
  input  logic       flag_done,
  input  logic       tx_buf_full,
  output logic       txd,
  output logic [1:0] loop_state,
  output logic       tx_go,
  output logic       tx_next_data,
  output logic       eop_pulse,
  output logic       poll_q
);

  localparam logic [W-1:0] EOP_PAT  = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] FLAG_PAT = {1'b0, {(W-2){1'b1}}, 1'b0};

  logic        loop_act, poll_eff;
  logic        eop_hit, flag_hit, go_active, hold, dly;
  loop_state_e st;

  assign loop_act = loop_en & sync_mode;
  assign poll_eff = poll_q & loop_act;

  loop_poll_bit u_poll (
    .clk      (clk),
    .rst_n    (rst_n),
    .chan_rst (chan_rst),
    .wr       (poll_wr),
    .wdata    (poll_wdata),
    .q        (poll_q)
  );

  loop_pat_det #(
    .W        (W),
    .EOP_PAT  (EOP_PAT),
    .FLAG_PAT (FLAG_PAT)
  ) u_det (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (chan_rst),
    .tick      (bit_tick),
    .rxd       (rxd),
    .eop_hit   (eop_hit),
    .flag_hit  (flag_hit),
    .eop_pulse (eop_pulse)
  );

  loop_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .chan_rst  (chan_rst),
    .loop_act  (loop_act),
    .tick      (bit_tick),
    .eop_hit   (eop_hit),
    .flag_hit  (flag_hit),
    .poll_eff  (poll_eff),
    .flag_done (flag_done),
    .buf_full  (tx_buf_full),
    .st        (st),
    .hold      (hold),
    .go_active (go_active),
    .next_data (tx_next_data)
  );

  // one-bit repeat register; the last pattern bit becomes zero on seizure
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        dly <= 1'b0;
    else if (chan_rst) dly <= 1'b0;
    else if (bit_tick) dly <= go_active ? 1'b0 : rxd;
  end

  always_comb begin
    if (!loop_act) begin
      txd = tx_bit;
    end else begin
      unique case (st)
        ST_BYPASS:  txd = rxd;
        ST_ON_LOOP: txd = dly;
        ST_ACTIVE:  txd = hold ? dly : tx_bit;
        default:    txd = rxd;
      endcase
    end
  end

  assign loop_state = st;
  assign tx_go      = (st == ST_ACTIVE) && !hold;

  // R3: the bit period after seizure carries a zero
  assert_flag_close_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ACTIVE && hold && loop_act) |-> (txd == 1'b0));

  // R10: only the three defined state codes appear
  assert_state_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
    loop_state != 2'd3);

endmodule

// File: tb/sdlc_loop_repeater_bench.sv
module sdlc_loop_repeater_bench;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, chan_rst, sync_mode, loop_en, poll_wr, poll_wdata;
  logic bit_tick, rxd, tx_bit, flag_done, tx_buf_full;
  logic txd, tx_go, tx_next_data, eop_pulse, poll_q;
  logic [1:0] loop_state;

  sdlc_loop_repeater u_sdlc_loop_repeater (
    .clk(clk), .rst_n(rst_n), .chan_rst(chan_rst), .sync_mode(sync_mode),
    .loop_en(loop_en), .poll_wr(poll_wr), .poll_wdata(poll_wdata),
    .bit_tick(bit_tick), .rxd(rxd), .tx_bit(tx_bit), .flag_done(flag_done),
    .tx_buf_full(tx_buf_full), .txd(txd), .loop_state(loop_state),
    .tx_go(tx_go), .tx_next_data(tx_next_data), .eop_pulse(eop_pulse),
    .poll_q(poll_q)
  );

  int    total = 0;
  int    bad = 0;
  int    eop_cnt = 0;
  int    exp_eop = 0;
  bit    done = 0;
  string phase = "R10";

  // behavioural reference
  int m_st;
  bit m_armed, m_hold, m_dly, m_nd, m_eop, m_pq;
  bit m_hist[$];

  function automatic void m_clear_hist();
    m_hist.delete();
    for (int i = 0; i < 8; i++) m_hist.push_back(1'b0);
  endfunction

  function automatic bit m_match(bit last);
    bit ok = (m_hist[0] == 1'b0) && (m_hist[7] == last);
    for (int i = 1; i < 7; i++) if (m_hist[i] != 1'b1) ok = 0;
    return ok;
  endfunction

  function automatic bit m_txd();
    if (!(loop_en && sync_mode)) return tx_bit;
    if (m_st == 0) return rxd;
    if (m_st == 1) return m_dly;
    return m_hold ? m_dly : tx_bit;
  endfunction

  function automatic void m_reset();
    m_st = 0; m_armed = 0; m_hold = 0; m_dly = 0; m_nd = 0; m_eop = 0; m_pq = 0;
    m_clear_hist();
  endfunction

  function automatic void m_step();
    bit la = loop_en && sync_mode;
    bit pe = m_pq && la;
    bit de = 0;
    bit df = 0;
    bit go = 0;
    if (!rst_n) begin m_reset(); return; end
    if (chan_rst) begin m_reset(); return; end
    if (poll_wr) m_pq = poll_wdata;
    if (bit_tick) begin
      m_hist.push_back(rxd);
      void'(m_hist.pop_front());
      de = m_match(1'b1);
      df = m_match(1'b0);
    end
    m_eop = bit_tick && de;
    if (!la) begin
      m_st = 0; m_armed = 0; m_hold = 0; m_nd = 0;
    end else if (m_st == 0) begin
      if (bit_tick && de && pe) begin m_st = 1; m_armed = 1; end
    end else if (m_st == 1) begin
      go = bit_tick && de && pe && m_armed;
      if (bit_tick && df) m_armed = 1;
      if (go) begin m_st = 2; m_hold = 1; end
    end else begin
      if (m_hold) begin
        if (bit_tick) m_hold = 0;
      end else if (flag_done) begin
        if (pe) m_nd = tx_buf_full;
        else begin m_st = 1; m_armed = 0; m_nd = 0; end
      end
    end
    if (bit_tick) m_dly = go ? 1'b0 : rxd;
  endfunction

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cyc();
    #1;
    chk(phase, "state", {6'd0, loop_state}, m_st[7:0]);
    chk(phase, "txd", {7'd0, txd}, {7'd0, m_txd()});
    chk(phase, "tx_go", {7'd0, tx_go}, {7'd0, (m_st == 2 && !m_hold)});
    chk(phase, "tx_next_data", {7'd0, tx_next_data}, {7'd0, m_nd});
    chk(phase, "eop_pulse", {7'd0, eop_pulse}, {7'd0, m_eop});
    chk(phase, "poll_q", {7'd0, poll_q}, {7'd0, m_pq});
    @(posedge clk);
    m_step();
    @(negedge clk);
  endtask

  task automatic send_bit(bit b);
    rxd = b; bit_tick = 1'b1; cyc();
    bit_tick = 1'b0; cyc(); cyc();
  endtask

  task automatic send_eop();
    send_bit(1'b0);
    for (int i = 0; i < 7; i++) send_bit(1'b1);
    exp_eop++;
  endtask

  task automatic write_poll(bit v);
    poll_wr = 1'b1; poll_wdata = v; cyc();
    poll_wr = 1'b0; cyc();
  endtask

  task automatic flag_strobe(bit full);
    tx_buf_full = full; flag_done = 1'b1; cyc();
    flag_done = 1'b0; cyc();
  endtask

  always @(negedge clk) if (rst_n && eop_pulse) eop_cnt++;

  initial begin
    #(200000 * 20);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; chan_rst = 0; sync_mode = 0; loop_en = 0; poll_wr = 0; poll_wdata = 0;
    bit_tick = 0; rxd = 1; tx_bit = 0; flag_done = 0; tx_buf_full = 0;
    m_reset();
    repeat (3) @(negedge clk);
    // R10: reset values
    phase = "R10";
    chk("R10", "reset state", {6'd0, loop_state}, 8'd0);
    chk("R10", "reset poll_q", {7'd0, poll_q}, 8'd0);
    chk("R10", "reset tx_go", {7'd0, tx_go}, 8'd0);
    chk("R10", "reset next", {7'd0, tx_next_data}, 8'd0);
    chk("R10", "reset eop", {7'd0, eop_pulse}, 8'd0);
    chk("R8", "hw reset clears poll", {7'd0, poll_q}, 8'd0);
    rst_n = 1;
    cyc();

    // R7: asynchronous mode ignores the poll bit
    phase = "R7";
    loop_en = 1; sync_mode = 0; tx_bit = 0;
    write_poll(1'b1);
    send_eop();
    chk("R7", "async stays bypass", {6'd0, loop_state}, 8'd0);
    rxd = 1; tx_bit = 0; #1;
    chk("R7", "async txd from tx_bit", {7'd0, txd}, 8'd0);
    cyc();

    // R1: bypass is a direct path
    phase = "R1";
    sync_mode = 1;
    write_poll(1'b0);
    rxd = 1; #1; chk("R1", "txd follows rxd hi", {7'd0, txd}, 8'd1);
    rxd = 0; #1; chk("R1", "txd follows rxd lo", {7'd0, txd}, 8'd0);
    cyc();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);

    // R2: end-of-poll needs the poll bit to insert the delay
    phase = "R2";
    send_eop();
    chk("R2", "no poll bit stays bypass", {6'd0, loop_state}, 8'd0);
    write_poll(1'b1);
    send_eop();
    chk("R2", "entered on-loop", {6'd0, loop_state}, 8'd1);
    rxd = 0; #1;
    chk("R2", "txd is delayed bit", {7'd0, txd}, 8'd1);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);

    // R3: seizure with the flag-closing zero
    phase = "R3";
    send_eop();
    chk("R3", "went active", {6'd0, loop_state}, 8'd2);
    chk("R3", "zero bit out", {7'd0, txd}, 8'd0);
    chk("R3", "shifter held", {7'd0, tx_go}, 8'd0);
    tx_bit = 1;
    send_bit(1'b1);
    chk("R3", "shifter runs", {7'd0, tx_go}, 8'd1);
    chk("R3", "txd from shifter", {7'd0, txd}, 8'd1);
    tx_bit = 0; send_bit(1'b1);

    // R4: flag boundary with permission kept
    phase = "R4";
    flag_strobe(1'b1);
    chk("R4", "data byte next", {7'd0, tx_next_data}, 8'd1);
    tx_bit = 1; send_bit(1'b1);
    flag_strobe(1'b0);
    chk("R4", "flag next", {7'd0, tx_next_data}, 8'd0);
    chk("R4", "still active", {6'd0, loop_state}, 8'd2);

    // R5: release at flag boundary
    phase = "R5";
    write_poll(1'b0);
    chk("R5", "no release without flag", {6'd0, loop_state}, 8'd2);
    flag_strobe(1'b1);
    chk("R5", "back on loop", {6'd0, loop_state}, 8'd1);
    chk("R5", "next cleared", {7'd0, tx_next_data}, 8'd0);
    send_bit(1'b0); send_bit(1'b1);

    // R6: re-arm needs a received flag
    phase = "R6";
    write_poll(1'b1);
    send_eop();
    chk("R6", "disarmed stays on loop", {6'd0, loop_state}, 8'd1);
    send_bit(1'b0);
    for (int i = 0; i < 6; i++) send_bit(1'b1);
    send_eop();
    chk("R6", "flag then eop seizes", {6'd0, loop_state}, 8'd2);

    // R7: loop disable forces bypass
    phase = "R7";
    loop_en = 0; tx_bit = 1; cyc();
    chk("R7", "loop off bypass", {6'd0, loop_state}, 8'd0);
    rxd = 0; #1;
    chk("R7", "loop off txd tx_bit", {7'd0, txd}, 8'd1);
    cyc();

    // R8: channel reset wins over write
    phase = "R8";
    loop_en = 1;
    chan_rst = 1; poll_wr = 1; poll_wdata = 1; cyc();
    chan_rst = 0; poll_wr = 0; cyc();
    chk("R8", "chan reset clears poll", {7'd0, poll_q}, 8'd0);
    chk("R8", "chan reset bypass", {6'd0, loop_state}, 8'd0);

    // R9: one pulse per end-of-poll
    phase = "R9";
    chk("R9", "eop pulse count", eop_cnt[7:0], exp_eop[7:0]);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule